// File: doc/BRIEF.md
# Video Bank Control Latch with Deferred Bank Switching

This block is an eight-bit control register that the CPU can only write. One write sets every field at once: the ROM page lines, a speaker mute bit, a select that chooses which video controller receives CPU writes to video memory, and one display-bank bit for each of the two video controllers. Each controller has two banks of video RAM. The controller displays from one bank while the CPU writes into the other.

The write-target select, the mute bit and the ROM page take effect as soon as the latch is loaded. The two display-bank bits do not. Each controller has its own deferral unit, and that unit copies its latch bit into an effective bank register only when the controller reports that one of its video RAM accesses has finished. So a bank change never lands in the middle of an access. While a controller is idle, a change to its bank bit has no effect. The first access after the change still uses the old bank, and the new bank applies when that access completes. A separate power-on mute input forces the amplifier off while it is high, whatever the latch holds.

Each deferral unit is a two-state machine. In state `DF_IN_STEP` the effective bank matches the requested bit. In state `DF_PENDING` the requested bit differs from the effective bank and the unit is waiting for an access-complete strobe. The unit makes the transition `REQ_CHANGE` (IN_STEP to PENDING) when the latch bit moves away from the effective bank. It makes the transition `APPLY` (PENDING to IN_STEP) on a strobe that copies the bit, and the transition `REVERT` (PENDING to IN_STEP) when the latch bit returns to the effective value. In all other cases the unit stays in its current state (`HOLD`).

Top module: `vbank_latch`

## Requirements
- R1: Reset (rst_n low) clears the latch and both effective banks. After reset, disp_bank is 0, cpu_bank is all ones, wr_target is 0, rom_page is 0, and amp_en is 1 when pwr_mute is low.
- R2: A clock edge with ld_stb high stores all eight bits of din. Bits 3:0 appear on rom_page after that edge. Without ld_stb, the stored byte does not change.
- R3: Stored bit 5 drives wr_target from the edge that loads it: 1 selects controller 2 and 0 selects controller 1.
- R4: Stored bit 4 set to 1 makes amp_en 0, and bit 4 set to 0 makes amp_en 1 while pwr_mute is low.
- R5: While pwr_mute is high, amp_en is 0 even when stored bit 4 is 0.
- R6: An edge with acc_done[i] high copies the stored bank bit into disp_bank[i]. The stored bit for index 0 (controller 1) is bit 6, and for index 1 (controller 2) it is bit 7.
- R7: Without an acc_done[i] strobe, disp_bank[i] holds its value even when the stored bank bit changes.
- R8: When a load and acc_done[i] fall on the same edge, disp_bank[i] takes the value that was stored before that load.
- R9: cpu_bank[i] is always the inverse of disp_bank[i].
- R10: A strobe for one controller leaves the other controller's disp_bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the CPU side and the access strobes |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_mute | input | 1 | Power-on mute pulse; forces the amplifier off while it is high |
| ld_stb | input | 1 | Load strobe; captures din |
| din | input | 8 | CPU data byte |
| acc_done | input | 2 | Single-cycle access-complete strobes; index 0 is controller 1, index 1 is controller 2 |
| disp_bank | output | 2 | Effective display bank per controller |
| cpu_bank | output | 2 | Bank reachable by the CPU per controller |
| wr_target | output | 1 | Controller that receives CPU video writes (1 = controller 2) |
| amp_en | output | 1 | Speaker amplifier enable |
| rom_page | output | 4 | ROM page select bits |

## Verification
The bench changes bank bits while a controller is idle and checks that disp_bank does not move. A design that applied bank bits directly would fail that check. It puts a load and an access-complete strobe on the same edge, where a design that forwarded din into the effective register would pick up the new bank one access too early. It also strobes one controller only, which exposes crossed bit indices, and holds pwr_mute high while bit 4 is 0, which catches a mute gate that ignores the pulse.

// File: rtl/vbank_latch_pkg.sv
package vbank_latch_pkg;

    localparam int unsigned LATCH_W   = 8;
    localparam int unsigned NUM_VC    = 2;
    localparam int unsigned PAGE_W    = 4;
    localparam int unsigned BANK_BIT0 = 6;

    typedef struct packed {
        logic              vc2_bank;
        logic              vc1_bank;
        logic              wr_sel;
        logic              mute;
        logic [PAGE_W-1:0] page;
    } latch_t;

    typedef enum logic {
        DF_IN_STEP = 1'b0,
        DF_PENDING = 1'b1
    } defer_state_t;

endpackage

// File: rtl/bl_ctrl_reg.sv
module bl_ctrl_reg
    import vbank_latch_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_stb,
    input  logic [LATCH_W-1:0] din,
    output latch_t             q
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (ld_stb)
            q <= latch_t'(din);
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_stb |=> $stable(q));

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_stb |=> (q == $past(din)));

endmodule

// File: rtl/bl_bank_defer.sv
module bl_bank_defer
    import vbank_latch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_bit,
    input  logic acc_done,
    output logic eff_bank
);

    defer_state_t state_q, state_d;
    logic         eff_d;

    always_comb begin
        eff_d   = eff_bank;
        state_d = state_q;
        unique case (state_q)
            DF_IN_STEP: begin
                if (acc_done)
                    eff_d = req_bit;
                if (eff_d != req_bit)
                    state_d = DF_PENDING;
            end
            DF_PENDING: begin
                if (acc_done) begin
                    eff_d   = req_bit;
                    state_d = DF_IN_STEP;
                end else if (req_bit == eff_bank) begin
                    state_d = DF_IN_STEP;
                end
            end
            default: state_d = DF_IN_STEP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= DF_IN_STEP;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            eff_bank <= 1'b0;
        else
            eff_bank <= eff_d;
    end

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_done |=> $stable(eff_bank));

    p_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |=> (eff_bank == $past(req_bit)));

    p_pending_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DF_PENDING && !acc_done) |=> $stable(eff_bank));

endmodule

// File: rtl/bl_amp_gate.sv
module bl_amp_gate (
    input  logic mute_bit,
    input  logic pwr_mute,
    output logic amp_en
);

    always_comb begin
        amp_en = 1'b1;
        if (pwr_mute || mute_bit)
            amp_en = 1'b0;
    end

    always_comb begin
        if (pwr_mute)
            p_forced_r5: assert (!amp_en);
    end

endmodule

// File: rtl/vbank_latch.sv
module vbank_latch
    import vbank_latch_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pwr_mute,
    input  logic                      ld_stb,
    input  logic [LATCH_W-1:0]        din,
    input  logic [NUM_VC-1:0]         acc_done,
    output logic [NUM_VC-1:0]         disp_bank,
    output logic [NUM_VC-1:0]         cpu_bank,
    output logic                      wr_target,
    output logic                      amp_en,
    output logic [PAGE_W-1:0]         rom_page
);

    latch_t           lat_q;
    logic [LATCH_W-1:0] lat_bits;

    assign lat_bits = lat_q;

    bl_ctrl_reg u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_stb (ld_stb),
        .din    (din),
        .q      (lat_q)
    );

    for (genvar gi = 0; gi < NUM_VC; gi++) begin : g_vc
        bl_bank_defer u_defer (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_bit  (lat_bits[BANK_BIT0 + gi]),
            .acc_done (acc_done[gi]),
            .eff_bank (disp_bank[gi])
        );
        assign cpu_bank[gi] = ~disp_bank[gi];
    end

    bl_amp_gate u_amp (
        .mute_bit (lat_q.mute),
        .pwr_mute (pwr_mute),
        .amp_en   (amp_en)
    );

    assign wr_target = lat_q.wr_sel;
    assign rom_page  = lat_q.page;

    p_wr_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_stb |=> (wr_target == $past(din[5])));

    p_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_stb |=> (rom_page == $past(din[PAGE_W-1:0])));

    p_mute_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_stb && din[4]) |=> !amp_en);

    p_isolate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_done == 2'b01) |=> $stable(disp_bank[1]));

endmodule

// File: tb/vbank_latch_tb_top.sv
module vbank_latch_tb_top;

    typedef struct {
        logic [1:0] disp;
        logic [1:0] cpu;
        logic       wr;
        logic       amp;
        logic [3:0] rom;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_mute = 1'b0;
    logic       ld_stb = 1'b0;
    logic [7:0] din = '0;
    logic [1:0] acc_done = '0;
    logic [1:0] disp_bank, cpu_bank;
    logic       wr_target, amp_en;
    logic [3:0] rom_page;

    int   n_checks = 0;
    int   n_fail   = 0;
    exp_t sb_q[$];
    event sb_ev;

    logic [7:0] m_lat = '0;
    logic [1:0] m_eff = '0;

    always #2.5 clk = ~clk;

    vbank_latch dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_mute  (pwr_mute),
        .ld_stb    (ld_stb),
        .din       (din),
        .acc_done  (acc_done),
        .disp_bank (disp_bank),
        .cpu_bank  (cpu_bank),
        .wr_target (wr_target),
        .amp_en    (amp_en),
        .rom_page  (rom_page)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always begin
        @(sb_ev);
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk(e.req, "disp_bank", disp_bank, e.disp);
            chk(e.req, "cpu_bank",  cpu_bank,  e.cpu);
            chk(e.req, "wr_target", wr_target, e.wr);
            chk(e.req, "amp_en",    amp_en,    e.amp);
            chk(e.req, "rom_page",  rom_page,  e.rom);
        end
    end

    task automatic step(input logic ld, input logic [7:0] d,
                        input logic [1:0] dn, input logic mu,
                        input logic rst, input string req);
        exp_t e;
        @(negedge clk);
        ld_stb = ld; din = d; acc_done = dn; pwr_mute = mu; rst_n = ~rst;
        @(posedge clk);
        if (rst) begin
            m_lat = '0; m_eff = '0;
        end else begin
            for (int i = 0; i < 2; i++)
                if (dn[i]) m_eff[i] = m_lat[6+i];
            if (ld) m_lat = d;
        end
        #1;
        e.disp = m_eff;
        e.cpu  = ~m_eff;
        e.wr   = m_lat[5];
        e.amp  = !mu && !m_lat[4];
        e.rom  = m_lat[3:0];
        e.req  = req;
        sb_q.push_back(e);
        -> sb_ev;
        #0.5;
    endtask

    initial begin
        #2000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        step(0, 8'h00, 2'b00, 0, 1, "R1");
        step(0, 8'h00, 2'b00, 0, 0, "R1");
        step(1, 8'h0F, 2'b00, 0, 0, "R2");
        step(0, 8'h33, 2'b00, 0, 0, "R2");
        step(1, 8'hA5, 2'b00, 0, 0, "R3");
        step(0, 8'h00, 2'b00, 0, 0, "R7");
        step(0, 8'h00, 2'b00, 0, 0, "R7");
        step(0, 8'h00, 2'b10, 0, 0, "R6");
        step(0, 8'h00, 2'b00, 0, 0, "R10");
        step(1, 8'h50, 2'b01, 0, 0, "R8");
        step(0, 8'h00, 2'b00, 0, 0, "R4");
        step(0, 8'h00, 2'b01, 0, 0, "R6");
        step(1, 8'h00, 2'b00, 0, 0, "R9");
        step(0, 8'h00, 2'b00, 1, 0, "R5");
        step(1, 8'h8C, 2'b00, 1, 0, "R5");
        step(0, 8'h00, 2'b01, 0, 0, "R10");
        step(0, 8'h00, 2'b10, 0, 0, "R6");
        step(1, 8'h40, 2'b11, 0, 0, "R8");
        step(0, 8'h00, 2'b11, 0, 0, "R9");
        step(1, 8'hFF, 2'b00, 0, 0, "R4");
        step(0, 8'h00, 2'b00, 0, 1, "R1");
        step(0, 8'h00, 2'b00, 0, 0, "R1");
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule